// File: doc/BRIEF.md
# UART Interrupt Request Generator

This block gathers the interrupt conditions of a 16550-style serial port into one active-high interrupt request line. It also produces a 4-bit identification code that names the most urgent pending cause. Four of the five causes are level inputs owned by neighbouring logic:

- receiver line error
- received data available
- character timeout
- modem status change

The fifth cause, transmitter holding register empty, is an event. This block keeps it in a pending latch of its own. A write to the holding register clears that latch. So does a read of the identification code at a moment when the code reports the transmitter cause.

A 4-bit enable value gates each cause. A FIFO-mode input qualifies the timeout cause. Both outputs are registered, so each one reflects the inputs and the latch state of the previous clock.

Top module: `uart_irq_gen`

## Requirements
- R1: `irq_o` is high in a cycle exactly when, one clock earlier, at least one enabled cause was pending.
- R2: The timeout cause counts only while `fifo_mode_i` is 1. With FIFO mode off, an active `rx_timeout_i` never raises `irq_o` and never yields code 1100.
- R3: Enable bit 0 gates both received data and timeout. Bit 1 gates the transmitter-empty latch. Bit 2 gates the line error cause. Bit 3 gates the modem cause.
- R4: When several causes are enabled and pending, the code reports one of them. The order, from highest to lowest, is: line error, then timeout, then received data, then transmitter empty, then modem.
- R5: Codes on `irq_id_o`:
  - 0001: nothing pending
  - 0110: line error
  - 1100: timeout
  - 0100: received data
  - 0010: transmitter empty
  - 0000: modem
- R6: A pulse on `thr_empty_evt_i` sets the transmitter-empty latch. The latch stays set until a clear event.
- R7: A pulse on `id_read_i` clears the latch only while `irq_id_o` shows 0010 in that cycle. At any other time the read leaves the latch untouched.
- R8: A pulse on `thr_write_i` clears the latch.
- R9: When an empty event and a clear event fall in the same cycle, the latch ends up set.
- R10: While `rst_n` is low, the latch is cleared, `irq_o` is 0 and `irq_id_o` is 0001.
- R11: The outputs follow the inputs with exactly one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 4 | Per-cause interrupt enables |
| fifo_mode_i | input | 1 | FIFO mode on; qualifies the timeout cause |
| line_err_i | input | 1 | Receiver line error condition (level) |
| rx_avail_i | input | 1 | Received data available condition (level) |
| rx_timeout_i | input | 1 | Character timeout condition (level) |
| modem_chg_i | input | 1 | Modem status change condition (level) |
| thr_empty_evt_i | input | 1 | Transmitter holding register became empty (pulse) |
| thr_write_i | input | 1 | Write to transmitter holding register (pulse) |
| id_read_i | input | 1 | Read of the identification code (pulse) |
| irq_o | output | 1 | Interrupt request, active high |
| irq_id_o | output | 4 | Code of the highest-priority pending cause |

## Verification
The block has no parameters, so the bench uses its single fixed build. That build has four enable bits and registered outputs. Each cause is exercised both alone and masked, and the priority ladder is removed one rung at a time. The latch clear rules are driven with reads that come both while a higher cause hides the transmitter code and while that code is visible. A long random run then compares both outputs every clock against a behavioural model. That run reaches the same-cycle set/clear collisions and FIFO-mode toggles.

// File: rtl/uart_irq_gen.sv
module uart_irq_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] enable_i,
  input  logic       fifo_mode_i,
  input  logic       line_err_i,
  input  logic       rx_avail_i,
  input  logic       rx_timeout_i,
  input  logic       modem_chg_i,
  input  logic       thr_empty_evt_i,
  input  logic       thr_write_i,
  input  logic       id_read_i,
  output logic       irq_o,
  output logic [3:0] irq_id_o
);
  localparam logic [3:0] ID_NONE  = 4'b0001;
  localparam logic [3:0] ID_LINE  = 4'b0110;
  localparam logic [3:0] ID_RXD   = 4'b0100;
  localparam logic [3:0] ID_TMO   = 4'b1100;
  localparam logic [3:0] ID_THRE  = 4'b0010;
  localparam logic [3:0] ID_MODEM = 4'b0000;

  logic thre_pend_q;

  wire act_line  = line_err_i   & enable_i[2];
  wire act_tmo   = rx_timeout_i & fifo_mode_i & enable_i[0];
  wire act_rxd   = rx_avail_i   & enable_i[0];
  wire act_thre  = thre_pend_q  & enable_i[1];
  wire act_modem = modem_chg_i  & enable_i[3];

  wire any_act   = act_line | act_tmo | act_rxd | act_thre | act_modem;
  wire thre_clr  = thr_write_i | (id_read_i & (irq_id_o == ID_THRE));

  logic [3:0] id_d;
  always_comb begin
    if      (act_line)  id_d = ID_LINE;
    else if (act_tmo)   id_d = ID_TMO;
    else if (act_rxd)   id_d = ID_RXD;
    else if (act_thre)  id_d = ID_THRE;
    else if (act_modem) id_d = ID_MODEM;
    else                id_d = ID_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_pend_q <= 1'b0;
      irq_o       <= 1'b0;
      irq_id_o    <= ID_NONE;
    end else begin
      if (thr_empty_evt_i) thre_pend_q <= 1'b1;
      else if (thre_clr)   thre_pend_q <= 1'b0;
      irq_o    <= any_act;
      irq_id_o <= id_d;
    end
  end

  // R1
  irq_matches_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (irq_id_o != ID_NONE));

  // R2
  tmo_needs_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode_i |=> irq_id_o != ID_TMO);

  // R4
  line_err_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err_i && enable_i[2]) |=> irq_id_o == ID_LINE);

  // R8
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_write_i && !thr_empty_evt_i) |=> !thre_pend_q);

  // R9
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_empty_evt_i |=> thre_pend_q);

  // R7
  hidden_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thre_pend_q && id_read_i && irq_id_o != ID_THRE && !thr_write_i) |=> thre_pend_q);
endmodule

// File: tb/sim_uart_irq_gen.sv
module sim_uart_irq_gen;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] en = 0;
  logic fifo = 0, lerr = 0, rxa = 0, tmo = 0, mdm = 0, evt = 0, wr = 0, rd = 0;
  logic irq;
  logic [3:0] id;

  always #5 clk = ~clk;

  uart_irq_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable_i(en), .fifo_mode_i(fifo),
    .line_err_i(lerr), .rx_avail_i(rxa), .rx_timeout_i(tmo), .modem_chg_i(mdm),
    .thr_empty_evt_i(evt), .thr_write_i(wr), .id_read_i(rd),
    .irq_o(irq), .irq_id_o(id));

  int vectors = 0, errors = 0;
  bit m_latch = 0, m_irq = 0;
  logic [3:0] m_id = 4'b0001;

  function automatic logic [3:0] pick_code(bit latch);
    if (lerr && en[2])              return 4'b0110;
    if (tmo && fifo && en[0])       return 4'b1100;
    if (rxa && en[0])               return 4'b0100;
    if (latch && en[1])             return 4'b0010;
    if (mdm && en[3])               return 4'b0000;
    return 4'b0001;
  endfunction

  task automatic compare(string tag);
    vectors++;
    if (irq !== m_irq || id !== m_id) begin
      errors++;
      $display("FAIL %s: irq=%0b id=%b expected irq=%0b id=%b", tag, irq, id, m_irq, m_id);
    end
  endtask

  task automatic step(string tag);
    logic [3:0] c;
    bit nl;
    @(posedge clk);
    if (!rst_n) begin
      m_latch = 0; m_irq = 0; m_id = 4'b0001;
    end else begin
      c = pick_code(m_latch);
      nl = m_latch;
      if (wr || (rd && m_id == 4'b0010)) nl = 0;
      if (evt) nl = 1;
      m_latch = nl;
      m_irq = (c != 4'b0001);
      m_id = c;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    lerr = 0; rxa = 0; tmo = 0; mdm = 0; evt = 0; wr = 0; rd = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    step("R10"); step("R10");
    lerr = 1; rxa = 1; en = 4'hF; evt = 1;
    step("R10");
    idle(); en = 0;
    @(negedge clk); rst_n = 1;
    step("R10");
    // R3: one cause with its own enable, then masked
    en = 4'b0100; lerr = 1; step("R3"); step("R3");
    en = 4'b1011; step("R3"); idle();
    en = 4'b0001; rxa = 1; step("R3"); step("R3");
    en = 4'b1110; step("R3"); idle();
    en = 4'b1000; mdm = 1; step("R3"); step("R3");
    en = 4'b0111; step("R3"); idle();
    // R2: timeout needs FIFO mode
    en = 4'b0001; tmo = 1; fifo = 0; step("R2"); step("R2");
    fifo = 1; step("R2"); step("R5");
    fifo = 0; step("R2"); idle();
    // R6: empty event sets latch
    en = 4'b0010; evt = 1; step("R6"); evt = 0; step("R6"); step("R6");
    // R8: write clears
    wr = 1; step("R8"); wr = 0; step("R8");
    // R4: full ladder, removed top down
    en = 4'hF; fifo = 1; evt = 1; step("R4"); evt = 0;
    lerr = 1; tmo = 1; rxa = 1; mdm = 1; step("R4"); step("R4");
    lerr = 0; step("R4"); step("R4");
    tmo = 0; step("R4"); step("R4");
    // R7: read while a higher cause hides the transmitter code
    rd = 1; step("R7"); rd = 0;
    rxa = 0; step("R7"); step("R7");
    rd = 1; step("R7"); rd = 0; step("R7"); step("R7");
    mdm = 0;
    // R9: set and clear together
    evt = 1; wr = 1; step("R9"); evt = 0; wr = 0; step("R9"); step("R9");
    evt = 1; rd = 1; step("R9"); evt = 0; rd = 0; step("R9");
    // R1 / R11: random traffic
    for (int i = 0; i < 4000; i++) begin
      en = 4'($urandom); fifo = 1'($urandom);
      lerr = ($urandom % 5) == 0; rxa = ($urandom % 3) == 0;
      tmo = ($urandom % 4) == 0; mdm = ($urandom % 4) == 0;
      evt = ($urandom % 4) == 0; wr = ($urandom % 6) == 0; rd = ($urandom % 3) == 0;
      step((i % 2) ? "R1" : "R11");
    end
    idle();
    step("R1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule